// File: doc/BRIEF.md
# Speculative RAW Dependence Tracker

This block sits next to one core's L1 cache and keeps track of read-after-write hazards between speculative threads without any central table. Every core holds the speculation degree of its running thread in a local version register. Speculative read misses seen on the shared bus carry the requester's core number and degree. When the requester is more speculative than the local thread, the read is remembered as pending for that line. A ring token visits each core in turn. The pending records are merged into a per-line invalidation vector, with one bit per core, only while this core holds that token.

When the local thread stores to a line whose vector is non-zero, the requesters recorded there have consumed stale data. The tracker does not squash them at once. It arms a fixed delay, and further stores made during that delay join the same batch. When the delay ends, one squash mask covering all armed lines is issued. Commit and abort of the local thread clear all tracking state. Abort discards any armed squash without issuing it. A small mode machine (idle, running, waiting for commit, squashed) decides when snoops and stores are considered.

Top module: `spec_raw_tracker`

## Requirements
- R1: After reset, mode_o is 0 (idle), ver_o is 0, and tok_o, squash_valid_o and squash_mask_o are all 0.
- R2: Mode encoding is idle=0, running=1, waiting-for-commit=2, squashed=3. A spawn_i in idle or squashed mode enters running mode and loads spawn_deg_i into ver_o. A done_i in running mode enters waiting-for-commit mode.
- R3: In running or waiting mode, a snoop whose degree is strictly greater than ver_o is recorded as pending for (snp_line_i, snp_core_i). A snoop with an equal or lower degree records nothing.
- R4: Snoops presented in idle or squashed mode record nothing.
- R5: A token sampled on tok_i at clock edge k, with nothing pending, appears on tok_o for exactly the one cycle that follows edge k+1.
- R6: If pending records exist while the token is held, they are merged into the invalidation vectors at edge k+1. The token is then held one more cycle and appears on tok_o after edge k+2.
- R7: A pending record has no effect on stores until it has been merged under the token.
- R8: A store (st_valid_i, running mode) to a line whose vector is non-zero arms a squash of DELAY_CYC (default 8) cycles. The squash is asserted for one cycle after the DELAY_CYC-th edge following the arming store. Its squash_mask_o bit c is set for core c and equals the OR of the vectors of every line armed during the delay, including bits merged during the delay. Those vectors are then cleared.
- R9: A store to a line whose vector is zero arms nothing.
- R10: commit_i in running or waiting mode enters idle mode, sets ver_o to 0, clears all vectors and pending records, and cancels an armed squash.
- R11: abort_i in running or waiting mode enters squashed mode, keeps ver_o, clears all vectors and pending records, and never issues the armed squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spawn_i | input | 1 | Start a speculative thread |
| spawn_deg_i | input | DEG_W | Speculation degree of the new thread |
| done_i | input | 1 | Local thread finished, awaiting commit |
| commit_i | input | 1 | Local thread commits |
| abort_i | input | 1 | Local thread is squashed |
| st_valid_i | input | 1 | Local store strobe |
| st_line_i | input | LINE_W | Line index of local store |
| snp_valid_i | input | 1 | Speculative read miss seen on bus |
| snp_core_i | input | CID_W | Requester core number |
| snp_deg_i | input | DEG_W | Requester speculation degree |
| snp_line_i | input | LINE_W | Line index of snooped read |
| tok_i | input | 1 | Snoop token arriving from ring |
| tok_o | output | 1 | Snoop token passed on the ring |
| squash_valid_o | output | 1 | Squash mask valid (one cycle) |
| squash_mask_o | output | NUM_CORES | Cores to squash |
| mode_o | output | 2 | Current speculative sub-mode |
| ver_o | output | DEG_W | Version priority register |

## Verification
Every result has a fixed latency. A snoop is recorded at the edge that samples it. The token leaves one edge after arrival with nothing pending, or two edges after arrival with records pending. A squash appears right after the eighth edge that follows the arming store. Mode and version changes are visible right after the edge that samples the strobe. The bench drives every input one time unit after a rising edge and checks outputs one time unit after a chosen later edge. Each check therefore names an exact edge count from its stimulus. The bench also checks the cycles just before a due result, so that early outputs are caught.

// File: rtl/raw_trk_pkg.sv
package raw_trk_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_RUN      = 2'd1,
    MODE_WAIT     = 2'd2,
    MODE_SQUASHED = 2'd3
  } spec_mode_e;
endpackage

// File: rtl/raw_mode_ctrl.sv
module raw_mode_ctrl
  import raw_trk_pkg::*;
#(
  parameter int DEG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spawn_i,
  input  logic [DEG_W-1:0] spawn_deg_i,
  input  logic             done_i,
  input  logic             commit_i,
  input  logic             abort_i,
  output spec_mode_e       mode_o,
  output logic [DEG_W-1:0] ver_o,
  output logic             active_o,
  output logic             flush_o
);
  spec_mode_e       mode_q;
  logic [DEG_W-1:0] ver_q;
  logic             active;

  assign active   = (mode_q == MODE_RUN) || (mode_q == MODE_WAIT);
  assign flush_o  = active && (abort_i || commit_i);
  assign active_o = active;
  assign mode_o   = mode_q;
  assign ver_o    = ver_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      ver_q  <= '0;
    end else if (active && abort_i) begin
      mode_q <= MODE_SQUASHED;
    end else if (active && commit_i) begin
      mode_q <= MODE_IDLE;
      ver_q  <= '0;
    end else if (spawn_i && (mode_q == MODE_IDLE || mode_q == MODE_SQUASHED)) begin
      mode_q <= MODE_RUN;
      ver_q  <= spawn_deg_i;
    end else if (done_i && mode_q == MODE_RUN) begin
      mode_q <= MODE_WAIT;
    end
  end
endmodule

// File: rtl/raw_snoop_token.sv
module raw_snoop_token #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int DEG_W     = 4,
  localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  active_i,
  input  logic                                  flush_i,
  input  logic [DEG_W-1:0]                      ver_i,
  input  logic                                  snp_valid_i,
  input  logic [CID_W-1:0]                      snp_core_i,
  input  logic [DEG_W-1:0]                      snp_deg_i,
  input  logic [LINE_W-1:0]                     snp_line_i,
  input  logic                                  tok_i,
  output logic                                  tok_o,
  output logic                                  apply_o,
  output logic [NUM_LINES-1:0][NUM_CORES-1:0]   pend_o
);
  logic [NUM_LINES-1:0][NUM_CORES-1:0] pend_q;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] hit;
  logic hold_q, extra_q, tok_q;
  logic snp_take, apply;

  // only more-speculative readers create a dependence
  assign snp_take = snp_valid_i && active_i && (snp_deg_i > ver_i);
  assign apply    = hold_q && !extra_q && (|pend_q);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign hit[l][c] = snp_take && (snp_line_i == LINE_W'(l)) &&
                         (snp_core_i == CID_W'(c));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend_q[l][c] <= 1'b0;
        else if (flush_i) pend_q[l][c] <= 1'b0;
        else              pend_q[l][c] <= (pend_q[l][c] && !apply) || hit[l][c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      extra_q <= 1'b0;
      tok_q   <= 1'b0;
    end else begin
      tok_q <= 1'b0;
      if (tok_i) begin
        hold_q  <= 1'b1;
        extra_q <= 1'b0;
      end else if (hold_q) begin
        if (apply) begin
          extra_q <= 1'b1;
        end else begin
          hold_q  <= 1'b0;
          extra_q <= 1'b0;
          tok_q   <= 1'b1;
        end
      end
    end
  end

  assign tok_o   = tok_q;
  assign apply_o = apply;
  assign pend_o  = pend_q;
endmodule

// File: rtl/raw_ivec_bank.sv
module raw_ivec_bank #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                flush_i,
  input  logic                                apply_i,
  input  logic [NUM_LINES-1:0][NUM_CORES-1:0] pend_i,
  input  logic [NUM_LINES-1:0]                clr_i,
  output logic [NUM_LINES-1:0][NUM_CORES-1:0] ivec_o
);
  logic [NUM_LINES-1:0][NUM_CORES-1:0] ivec_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_CORES-1:0] kept, added;
    assign kept  = clr_i[l] ? '0 : ivec_q[l];
    assign added = apply_i ? pend_i[l] : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ivec_q[l] <= '0;
      else if (flush_i) ivec_q[l] <= '0;
      else              ivec_q[l] <= kept | added;
    end
  end

  assign ivec_o = ivec_q;
endmodule

// File: rtl/raw_squash_delay.sv
module raw_squash_delay #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int DELAY_CYC = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W    = $clog2(DELAY_CYC + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                flush_i,
  input  logic                                st_en_i,
  input  logic [LINE_W-1:0]                   st_line_i,
  input  logic [NUM_LINES-1:0][NUM_CORES-1:0] ivec_i,
  output logic [NUM_LINES-1:0]                clr_o,
  output logic                                squash_valid_o,
  output logic [NUM_CORES-1:0]                squash_mask_o
);
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_LINES-1:0] armed_q, st_hit, arm_eff;
  logic [NUM_CORES-1:0] mask_acc, mask_q;
  logic                 fire, valid_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_hit
    assign st_hit[l] = st_en_i && (st_line_i == LINE_W'(l)) && (|ivec_i[l]);
  end

  assign arm_eff = armed_q | st_hit;
  assign fire    = (cnt_q == CNT_W'(1)) && !flush_i;

  always_comb begin
    mask_acc = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (arm_eff[l]) mask_acc = mask_acc | ivec_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= '0;
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      if (flush_i) begin
        cnt_q   <= '0;
        armed_q <= '0;
      end else if (fire) begin
        cnt_q   <= '0;
        armed_q <= '0;
        valid_q <= 1'b1;
        mask_q  <= mask_acc;
      end else if (cnt_q != '0) begin
        cnt_q   <= cnt_q - CNT_W'(1);
        armed_q <= arm_eff;
      end else if (|st_hit) begin
        cnt_q   <= CNT_W'(DELAY_CYC);
        armed_q <= st_hit;
      end
    end
  end

  assign clr_o          = fire ? arm_eff : '0;
  assign squash_valid_o = valid_q;
  assign squash_mask_o  = mask_q;
endmodule

// File: rtl/spec_raw_tracker.sv
module spec_raw_tracker
  import raw_trk_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int DEG_W     = 4,
  parameter int DELAY_CYC = 8,
  localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 spawn_i,
  input  logic [DEG_W-1:0]     spawn_deg_i,
  input  logic                 done_i,
  input  logic                 commit_i,
  input  logic                 abort_i,
  input  logic                 st_valid_i,
  input  logic [LINE_W-1:0]    st_line_i,
  input  logic                 snp_valid_i,
  input  logic [CID_W-1:0]     snp_core_i,
  input  logic [DEG_W-1:0]     snp_deg_i,
  input  logic [LINE_W-1:0]    snp_line_i,
  input  logic                 tok_i,
  output logic                 tok_o,
  output logic                 squash_valid_o,
  output logic [NUM_CORES-1:0] squash_mask_o,
  output logic [1:0]           mode_o,
  output logic [DEG_W-1:0]     ver_o
);
  spec_mode_e                          mode;
  logic                                active, flush, apply;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] pend, ivec;
  logic [NUM_LINES-1:0]                clr;

  raw_mode_ctrl #(.DEG_W(DEG_W)) u_mode (
    .clk_i, .rst_ni,
    .spawn_i, .spawn_deg_i, .done_i, .commit_i, .abort_i,
    .mode_o(mode), .ver_o, .active_o(active), .flush_o(flush)
  );

  raw_snoop_token #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .DEG_W(DEG_W)) u_snoop (
    .clk_i, .rst_ni,
    .active_i(active), .flush_i(flush), .ver_i(ver_o),
    .snp_valid_i, .snp_core_i, .snp_deg_i, .snp_line_i,
    .tok_i, .tok_o, .apply_o(apply), .pend_o(pend)
  );

  raw_ivec_bank #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_ivec (
    .clk_i, .rst_ni,
    .flush_i(flush), .apply_i(apply), .pend_i(pend), .clr_i(clr), .ivec_o(ivec)
  );

  raw_squash_delay #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .DELAY_CYC(DELAY_CYC)) u_delay (
    .clk_i, .rst_ni,
    .flush_i(flush), .st_en_i(st_valid_i && mode == MODE_RUN), .st_line_i,
    .ivec_i(ivec), .clr_o(clr), .squash_valid_o, .squash_mask_o
  );

  assign mode_o = mode;
endmodule

// File: rtl/spec_raw_tracker_chk.sv
module spec_raw_tracker_chk #(
  parameter int NUM_CORES = 4,
  parameter int DEG_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 commit_i,
  input logic                 abort_i,
  input logic                 tok_i,
  input logic                 tok_o,
  input logic                 squash_valid_o,
  input logic [NUM_CORES-1:0] squash_mask_o,
  input logic [1:0]           mode_o,
  input logic [DEG_W-1:0]     ver_o
);
  logic active;
  assign active = (mode_o == 2'd1) || (mode_o == 2'd2);

  assert_tok_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |=> !tok_o);
  assert_tok_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |-> ($past(tok_i, 2) || $past(tok_i, 3)));
  assert_sq_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |=> !squash_valid_o);
  assert_sq_mask_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |-> (squash_mask_o != '0));
  assert_mask_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !squash_valid_o |-> (squash_mask_o == '0));
  assert_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i && active) |=> (mode_o == 2'd0 && ver_o == '0 && !squash_valid_o));
  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && active) |=> (mode_o == 2'd3 && !squash_valid_o && $stable(ver_o)));
  assert_quiet_modes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd3) |-> !squash_valid_o);
endmodule

bind spec_raw_tracker spec_raw_tracker_chk #(.NUM_CORES(NUM_CORES), .DEG_W(DEG_W)) u_chk (
  .clk_i, .rst_ni, .commit_i, .abort_i, .tok_i, .tok_o,
  .squash_valid_o, .squash_mask_o, .mode_o, .ver_o
);

// File: tb/spec_raw_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_raw_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spawn = 0, done = 0, commit = 0, abort = 0;
  logic [3:0] spawn_deg = '0;
  logic       st_v = 0;
  logic [2:0] st_line = '0;
  logic       snp_v = 0;
  logic [1:0] snp_core = '0;
  logic [3:0] snp_deg = '0;
  logic [2:0] snp_line = '0;
  logic       tok_in = 0;
  logic       tok_out, sq_v;
  logic [3:0] sq_mask, ver;
  logic [1:0] mode;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spec_raw_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .spawn_i(spawn), .spawn_deg_i(spawn_deg), .done_i(done),
    .commit_i(commit), .abort_i(abort),
    .st_valid_i(st_v), .st_line_i(st_line),
    .snp_valid_i(snp_v), .snp_core_i(snp_core), .snp_deg_i(snp_deg), .snp_line_i(snp_line),
    .tok_i(tok_in), .tok_o(tok_out),
    .squash_valid_o(sq_v), .squash_mask_o(sq_mask), .mode_o(mode), .ver_o(ver)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one rising edge samples the inputs set before the call; strobes then drop
  task automatic tick();
    @(posedge clk); #1;
    spawn = 0; done = 0; commit = 0; abort = 0; st_v = 0; snp_v = 0; tok_in = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [3:0] d, input logic [2:0] l);
    snp_v = 1; snp_core = c; snp_deg = d; snp_line = l; tick();
  endtask

  task automatic token(input bit pend, input string tag);
    tok_in = 1; tick();
    chk({tag, " tok k"}, tok_out, 0);
    tick(); chk({tag, " tok k+1"}, tok_out, !pend);
    tick(); chk({tag, " tok k+2"}, tok_out, pend);
    tick(); chk({tag, " tok k+3"}, tok_out, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (sq_v) seen = 1; end
    chk({tag, " no squash"}, seen, 0);
  endtask

  task automatic store_expect(input logic [2:0] l, input logic [3:0] mask, input string tag);
    bit early = 0;
    st_v = 1; st_line = l; tick();
    for (int i = 0; i < 7; i++) begin tick(); if (sq_v) early = 1; end
    chk({tag, " early squash"}, early, 0);
    tick(); chk({tag, " squash valid"}, sq_v, 1); chk({tag, " squash mask"}, sq_mask, mask);
    tick(); chk({tag, " squash one cycle"}, sq_v, 0);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0); chk("R1 ver", ver, 0);
    chk("R1 tok", tok_out, 0); chk("R1 sq", sq_v, 0); chk("R1 mask", sq_mask, 0);
  endtask

  task automatic t_spawn();
    spawn = 1; spawn_deg = 5; tick();
    chk("R2 mode run", mode, 1); chk("R2 ver", ver, 5);
  endtask

  task automatic t_token_plain();
    token(0, "R5");
  endtask

  task automatic t_dep_basic();
    snoop(2, 7, 3);
    st_v = 1; st_line = 3; tick();
    quiet(10, "R7 R9 unmerged");
    token(1, "R6");
    store_expect(3, 4'b0100, "R8 basic");
  endtask

  task automatic t_low_degree();
    snoop(1, 5, 2); snoop(3, 3, 2);
    token(0, "R3 low degree");
    st_v = 1; st_line = 2; tick();
    quiet(10, "R3 low degree store");
  endtask

  task automatic t_accumulate();
    bit early = 0;
    snoop(1, 9, 4); snoop(3, 9, 5);
    token(1, "R6 merge two");
    st_v = 1; st_line = 4; tick();                       // E0
    snp_v = 1; snp_core = 0; snp_deg = 9; snp_line = 4; tick(); // E1
    if (sq_v) early = 1;
    tok_in = 1; tick(); if (sq_v) early = 1;             // E2
    tick(); if (sq_v) early = 1;                         // E3 merge
    st_v = 1; st_line = 5; tick(); if (sq_v) early = 1;  // E4
    for (int i = 0; i < 3; i++) begin tick(); if (sq_v) early = 1; end
    chk("R8 accum early", early, 0);
    tick(); chk("R8 accum valid", sq_v, 1); chk("R8 accum mask", sq_mask, 4'b1011);
    tick(); chk("R8 accum one cycle", sq_v, 0);
    st_v = 1; st_line = 4; tick(); quiet(10, "R8 line4 cleared");
    st_v = 1; st_line = 5; tick(); quiet(10, "R8 line5 cleared");
  endtask

  task automatic t_wait_commit();
    done = 1; tick(); chk("R2 mode wait", mode, 2);
    snoop(2, 9, 1);
    token(1, "R3 wait mode");
    commit = 1; tick();
    chk("R10 mode", mode, 0); chk("R10 ver", ver, 0);
  endtask

  task automatic t_idle_ignore();
    snoop(2, 9, 1);
    token(0, "R4 idle");
  endtask

  task automatic t_abort();
    spawn = 1; spawn_deg = 2; tick();
    snoop(3, 4, 6);
    token(1, "R6 abort setup");
    st_v = 1; st_line = 6; tick();
    tick(); tick();
    abort = 1; tick();
    chk("R11 mode", mode, 3); chk("R11 ver kept", ver, 2);
    quiet(12, "R11 abort");
    snoop(1, 9, 6);
    token(0, "R4 squashed");
    spawn = 1; spawn_deg = 1; tick();
    chk("R2 respawn", mode, 1);
    st_v = 1; st_line = 6; tick();
    quiet(10, "R11 vectors cleared");
  endtask

  task automatic t_commit_cancel();
    snoop(1, 6, 0);
    token(1, "R6 commit setup");
    st_v = 1; st_line = 0; tick();
    tick(); tick();
    commit = 1; tick();
    quiet(12, "R10 cancel");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_spawn();
    t_token_plain();
    t_dep_basic();
    t_low_degree();
    t_accumulate();
    t_wait_commit();
    t_idle_ignore();
    t_abort();
    t_commit_cancel();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule